// File: doc/BRIEF.md
# Memory-Side Data Bus Drive and Termination Controller

This block sits on the memory side of a bidirectional data bus and decides, each cycle, what the data pins do. On every rising clock edge it samples the read/write select pin (`rnw_i`, high selects the read side) and the active-low load pin (`load_n_i`). From these two pins it picks one of three bus modes. In DRIVE_LOW the pins are driven to logic low. In DRIVE_DATA the pins are driven with array read data. In TERMINATE the drivers are off and on-die input termination is on. Whenever the memory is not sending data or receiving write data, the bus is held actively low. The bus therefore never floats, and it is never left terminated with nothing driving it.

A read command starts a read-data window. The window opens `READ_LATENCY` cycles after the read is sampled and stays open for `BURST_LEN` beats. The block also reports the decoded command: READ, WRITE, a read-side no-op (NOP_R) or a write-side no-op (NOP_W). The controller uses the no-op kinds to park the memory in the correct mode before and after each burst. All outputs are registered. Each one takes the value decided from the sample at the most recent rising edge.

The mode state machine has three states and these transitions:
- DRIVE_LOW, DRIVE_DATA or TERMINATE go to TERMINATE (`go_term`) when `rnw_i` is sampled low.
- Any state goes to DRIVE_DATA (`go_data`) when `rnw_i` is sampled high and the read window is open in the next cycle.
- Any state goes to DRIVE_LOW (`go_low`) when `rnw_i` is sampled high and no window is open.

Top module: `dq_bus_ctl`

## Requirements
- R1: While reset is asserted, and after it is released until the first sample, the outputs are in this state: `mode_o`=DRIVE_LOW (2'b00), `drv_en_o`=1, `drv_data_o`=0, `term_en_o`=0 and `cmd_o`=NOP_R (2'b10).
- R2: After each rising edge, `cmd_o` gives the command sampled at that edge as {`load_n_i`, ~`rnw_i`}: READ=2'b00, WRITE=2'b01, NOP_R=2'b10, NOP_W=2'b11.
- R3: After an edge that samples `rnw_i` low, whatever `load_n_i` is, `term_en_o`=1, `drv_en_o`=0, `drv_data_o`=0 and `mode_o`=TERMINATE (2'b10).
- R4: After an edge that samples `rnw_i` high, whatever `load_n_i` is, `term_en_o`=0 and `drv_en_o`=1. `drv_data_o` is 0 and `mode_o` is DRIVE_LOW unless that cycle is a read-data beat.
- R5: After a READ sampled at edge k, the cycles after edges k+READ_LATENCY through k+READ_LATENCY+BURST_LEN-1 are read-data beats. In those cycles, if `rnw_i` was sampled high, `drv_data_o`=1 and `mode_o`=DRIVE_DATA (2'b01).
- R6: After reset, exactly one of `drv_en_o` and `term_en_o` is high in every cycle.
- R7: A beat cycle whose edge samples `rnw_i` low is terminated and its data is dropped. The remaining beats of that burst keep their original cycles.
- R8: A READ whose window overlaps a pending window extends the data beats without a gap, up to the end of the later READ's window.
- R9: `drv_data_o` is high only when `drv_en_o` is high and `mode_o` is DRIVE_DATA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnw_i | input | 1 | Read/write select: 1 = read side, 0 = write side |
| load_n_i | input | 1 | Active-low load: 0 = READ/WRITE command, 1 = no-op |
| drv_en_o | output | 1 | Data output driver enable |
| drv_data_o | output | 1 | Drive-value select: 1 = array data, 0 = logic low |
| term_en_o | output | 1 | On-die input termination enable |
| cmd_o | output | 2 | Decoded command of the last sample |
| mode_o | output | 2 | Current bus mode: 00 DRIVE_LOW, 01 DRIVE_DATA, 10 TERMINATE |

## Verification
A wrong mode state shows at the pins in the very next cycle. Every port after an edge depends only on that edge's sample and on the read window, so a stuck or mis-decoded state gives a forbidden pair of driver and termination enables, or a `mode_o` value that disagrees with the pin just sampled. A fault in the read-latency line or in the beat counter shows up as beats that start or end one cycle off, or as a gap between overlapping reads. That error only appears `READ_LATENCY` to `READ_LATENCY+BURST_LEN` cycles after the READ, so the directed tests check every cycle of the window, and the cycles just outside it.

// File: rtl/dqc_pkg.sv
package dqc_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_NOP_R = 2'b10,
        CMD_NOP_W = 2'b11
    } dqc_cmd_e;

    typedef enum logic [1:0] {
        MODE_DRIVE_LOW  = 2'b00,
        MODE_DRIVE_DATA = 2'b01,
        MODE_TERMINATE  = 2'b10
    } dqc_mode_e;

endpackage

// File: rtl/dqc_cmd_decode.sv
module dqc_cmd_decode
    import dqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rnw_i,
    input  logic     load_n_i,
    output logic     rd_start_o,
    output dqc_cmd_e cmd_q_o
);

    dqc_cmd_e cmd_d;

    always_comb begin
        unique case ({load_n_i, rnw_i})
            2'b01:   cmd_d = CMD_READ;
            2'b00:   cmd_d = CMD_WRITE;
            2'b11:   cmd_d = CMD_NOP_R;
            default: cmd_d = CMD_NOP_W;
        endcase
    end

    assign rd_start_o = (cmd_d == CMD_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q_o <= CMD_NOP_R;
        end else begin
            cmd_q_o <= cmd_d;
        end
    end

endmodule

// File: rtl/dqc_read_window.sv
module dqc_read_window #(
    parameter int READ_LATENCY = 2,
    parameter int BURST_LEN    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_start_i,
    output logic win_next_o
);

    localparam int CNT_W = $clog2(BURST_LEN + 1);
    localparam logic [CNT_W-1:0] BEATS = CNT_W'(BURST_LEN);

    logic [READ_LATENCY-1:0] dly_q;
    logic [CNT_W-1:0]        beats_q;
    logic [CNT_W-1:0]        beats_d;
    logic                    tap;

    // latency delay line; its last stage arms the beat counter
    generate
        if (READ_LATENCY == 1) begin : g_lat1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dly_q <= '0;
                else        dly_q <= rd_start_i;
            end
        end else begin : g_latn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dly_q <= '0;
                else        dly_q <= {dly_q[READ_LATENCY-2:0], rd_start_i};
            end
        end
    endgenerate

    assign tap = dly_q[READ_LATENCY-1];

    always_comb begin
        if (tap) begin
            beats_d = BEATS;
        end else if (beats_q != '0) begin
            beats_d = beats_q - 1'b1;
        end else begin
            beats_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beats_q <= '0;
        else        beats_q <= beats_d;
    end

    assign win_next_o = (beats_d != '0);

endmodule

// File: rtl/dqc_mode_fsm.sv
module dqc_mode_fsm
    import dqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rnw_i,
    input  logic      win_next_i,
    output dqc_mode_e mode_o,
    output logic      drv_en_o,
    output logic      drv_data_o,
    output logic      term_en_o
);

    dqc_mode_e state_q;
    dqc_mode_e state_d;

    // transitions go_term / go_data / go_low, identical from every state
    always_comb begin
        unique case (state_q)
            MODE_DRIVE_LOW, MODE_DRIVE_DATA, MODE_TERMINATE: begin
                if (!rnw_i)          state_d = MODE_TERMINATE;
                else if (win_next_i) state_d = MODE_DRIVE_DATA;
                else                 state_d = MODE_DRIVE_LOW;
            end
            default: state_d = MODE_DRIVE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_DRIVE_LOW;
        else        state_q <= state_d;
    end

    // registered pad controls, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_en_o   <= 1'b1;
            drv_data_o <= 1'b0;
            term_en_o  <= 1'b0;
        end else begin
            unique case (state_d)
                MODE_TERMINATE: begin
                    drv_en_o   <= 1'b0;
                    drv_data_o <= 1'b0;
                    term_en_o  <= 1'b1;
                end
                MODE_DRIVE_DATA: begin
                    drv_en_o   <= 1'b1;
                    drv_data_o <= 1'b1;
                    term_en_o  <= 1'b0;
                end
                default: begin
                    drv_en_o   <= 1'b1;
                    drv_data_o <= 1'b0;
                    term_en_o  <= 1'b0;
                end
            endcase
        end
    end

    assign mode_o = state_q;

endmodule

// File: rtl/dq_bus_ctl.sv
module dq_bus_ctl
    import dqc_pkg::*;
#(
    parameter int READ_LATENCY = 2,
    parameter int BURST_LEN    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rnw_i,
    input  logic       load_n_i,
    output logic       drv_en_o,
    output logic       drv_data_o,
    output logic       term_en_o,
    output logic [1:0] cmd_o,
    output logic [1:0] mode_o
);

    dqc_cmd_e  cmd_q;
    dqc_mode_e mode_q;
    logic      rd_start;
    logic      win_next;

    dqc_cmd_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .rnw_i      (rnw_i),
        .load_n_i   (load_n_i),
        .rd_start_o (rd_start),
        .cmd_q_o    (cmd_q)
    );

    dqc_read_window #(
        .READ_LATENCY (READ_LATENCY),
        .BURST_LEN    (BURST_LEN)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_start_i (rd_start),
        .win_next_o (win_next)
    );

    dqc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rnw_i      (rnw_i),
        .win_next_i (win_next),
        .mode_o     (mode_q),
        .drv_en_o   (drv_en_o),
        .drv_data_o (drv_data_o),
        .term_en_o  (term_en_o)
    );

    assign cmd_o  = cmd_q;
    assign mode_o = mode_q;

endmodule

// File: rtl/dq_bus_ctl_chk.sv
module dq_bus_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rnw_i,
    input logic       load_n_i,
    input logic       drv_en_o,
    input logic       drv_data_o,
    input logic       term_en_o,
    input logic [1:0] cmd_o,
    input logic [1:0] mode_o
);

    a_r6_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o != term_en_o);

    a_r3_write_side_terminates: assert property (@(posedge clk) disable iff (!rst_n)
        !rnw_i |=> (term_en_o && !drv_en_o && mode_o == 2'b10));

    a_r4_read_side_drives: assert property (@(posedge clk) disable iff (!rst_n)
        rnw_i |=> (!term_en_o && drv_en_o && mode_o != 2'b10));

    a_r9_data_needs_driver: assert property (@(posedge clk) disable iff (!rst_n)
        drv_data_o |-> (drv_en_o && mode_o == 2'b01));

    a_r2_cmd_follows_pins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cmd_o == {$past(load_n_i), ~$past(rnw_i)}));

endmodule

bind dq_bus_ctl dq_bus_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rnw_i      (rnw_i),
    .load_n_i   (load_n_i),
    .drv_en_o   (drv_en_o),
    .drv_data_o (drv_data_o),
    .term_en_o  (term_en_o),
    .cmd_o      (cmd_o),
    .mode_o     (mode_o)
);

// File: tb/dq_bus_ctl_tb.sv
`timescale 1ns/1ps
module dq_bus_ctl_tb;

    localparam logic [1:0] M_LOW  = 2'b00;
    localparam logic [1:0] M_DATA = 2'b01;
    localparam logic [1:0] M_TERM = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rnw = 1'b1;
    logic       load_n = 1'b1;
    logic       drv_en, drv_data, term_en;
    logic [1:0] cmd, mode;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dq_bus_ctl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rnw_i      (rnw),
        .load_n_i   (load_n),
        .drv_en_o   (drv_en),
        .drv_data_o (drv_data),
        .term_en_o  (term_en),
        .cmd_o      (cmd),
        .mode_o     (mode)
    );

    task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // full port check for an expected mode
    task automatic chk_mode(input string req, input logic [1:0] m);
        chk(req, "mode", mode, m);
        chk(req, "drv_en", {1'b0, drv_en}, {1'b0, m != M_TERM});
        chk(req, "term_en", {1'b0, term_en}, {1'b0, m == M_TERM});
        chk(req, "drv_data", {1'b0, drv_data}, {1'b0, m == M_DATA});
        chk("R6", "one enable", {1'b0, drv_en ^ term_en}, 2'b01);
        chk("R9", "data implies driver", {1'b0, drv_data & ~drv_en}, 2'b00);
    endtask

    // drive one sample, wait for its edge, check at the falling edge after it
    task automatic step(input string req, input logic r, input logic l, input logic [1:0] m);
        rnw = r;
        load_n = l;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "cmd", cmd, {l, ~r});
        chk_mode(req, m);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_mode("R1", M_LOW);
        chk("R1", "cmd", cmd, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk_mode("R1", M_LOW);
    endtask

    task automatic t_decode_and_write();
        step("R3", 1'b0, 1'b1, M_TERM);
        step("R3", 1'b0, 1'b0, M_TERM);
        step("R3", 1'b0, 1'b1, M_TERM);
        step("R4", 1'b1, 1'b1, M_LOW);
        step("R4", 1'b1, 1'b1, M_LOW);
    endtask

    task automatic t_read_burst();
        step("R4", 1'b1, 1'b0, M_LOW);
        step("R5", 1'b1, 1'b1, M_LOW);
        step("R5", 1'b1, 1'b1, M_DATA);
        step("R5", 1'b1, 1'b1, M_DATA);
        step("R5", 1'b1, 1'b1, M_LOW);
        step("R5", 1'b1, 1'b1, M_LOW);
    endtask

    task automatic t_overlap();
        step("R8", 1'b1, 1'b0, M_LOW);
        step("R8", 1'b1, 1'b0, M_LOW);
        step("R8", 1'b1, 1'b1, M_DATA);
        step("R8", 1'b1, 1'b1, M_DATA);
        step("R8", 1'b1, 1'b1, M_DATA);
        step("R8", 1'b1, 1'b1, M_LOW);
    endtask

    task automatic t_write_in_window();
        step("R7", 1'b1, 1'b0, M_LOW);
        step("R7", 1'b1, 1'b1, M_LOW);
        step("R7", 1'b0, 1'b1, M_TERM);
        step("R7", 1'b1, 1'b1, M_DATA);
        step("R7", 1'b1, 1'b1, M_LOW);
    endtask

    task automatic t_write_after_read();
        step("R5", 1'b1, 1'b0, M_LOW);
        step("R5", 1'b1, 1'b1, M_LOW);
        step("R5", 1'b1, 1'b1, M_DATA);
        step("R5", 1'b1, 1'b1, M_DATA);
        step("R3", 1'b0, 1'b0, M_TERM);
        step("R4", 1'b1, 1'b1, M_LOW);
    endtask

    initial begin
        t_reset();
        t_decode_and_write();
        t_read_burst();
        t_overlap();
        t_write_in_window();
        t_write_after_read();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule